// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer

This block is a single timer channel. A 32-bit counter steps down by one on every selected tick, from a programmable reload value to zero. When it reaches zero it returns to the reload value on the next tick and keeps running. The tick is either every system clock or a strobe from an external 1 MHz tick source, chosen by an input.

Two match registers mark points on the way down. An interrupt event happens when the count lands on either match point. An event also happens when the count lands on zero, if overflow interrupts are enabled or if either match point counts as zero. Each event inverts a level-type interrupt line and sets a sticky status flag. The flag stays set until it is cleared by a strobe.

Software-facing registers are presented as plain write strobes with data. The bus decode sits outside the block. While the channel is disabled, the count output shows the reload value instead of the frozen count.

Top module: `dmatch_timer`

## Requirements
- R1: After a synchronous active-low reset, count_out is 0, irq_level is 0 and irq_status is 0. The reload value and both match values are 0.
- R2: While enabled with a nonzero reload value, each tick lowers the count by one. A tick taken at count 0 loads the reload value held before that tick.
- R3: With tick_sel = 0 every system clock is a tick. With tick_sel = 1 only clocks with ext_tick = 1 are ticks.
- R4: While run_en = 0, the cycle after run_en falls and every later cycle shows count_out equal to the reload value. No event happens and irq_level holds.
- R5: A clock on which run_en rises (it was 0 on the previous clock) loads the count with the reload value, including any value written on that same clock.
- R6: While enabled, count_wr replaces the running count with count_wdata, and no tick is taken on that clock. While disabled, count_wr has no effect on the count seen after the next enable.
- R7: While enabled, writing a nonzero reload value when the held reload is 0 starts counting from the written value. While the held reload is 0, no tick is taken.
- R8: A match value greater than or equal to the held reload value is treated as zero.
- R9: A tick whose new count is nonzero and equal to either effective match value is an event. A larger match point fires before a smaller one.
- R10: A tick whose new count is 0 is an event when ovf_irq_en = 1 or either effective match value is 0.
- R11: Each event inverts irq_level and sets irq_status. A tick yields at most one event, even when both match values are equal.
- R12: irq_status stays set until status_clr is high on a clock with no event. An event on the same clock keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_sel | input | 1 | 1: count on ext_tick strobes; 0: count on every clock |
| ext_tick | input | 1 | One-clock strobe from the 1 MHz tick source |
| run_en | input | 1 | Channel enable |
| ovf_irq_en | input | 1 | Event on reaching zero |
| count_wr | input | 1 | Write strobe for the running count |
| count_wdata | input | 32 | New running count |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_wdata | input | 32 | New reload value |
| match_a_wr | input | 1 | Write strobe for match point A |
| match_a_wdata | input | 32 | New match point A |
| match_b_wr | input | 1 | Write strobe for match point B |
| match_b_wdata | input | 32 | New match point B |
| status_clr | input | 1 | Clear strobe for irq_status |
| count_out | output | 32 | Live count while enabled, reload value while disabled |
| irq_level | output | 1 | Interrupt line that inverts on every event |
| irq_status | output | 1 | Sticky event flag |

## Verification
The bound checker watches, on every clock, that a disabled channel never moves its interrupt line and that a disabled channel holds a steady count output. It also checks that every change of the interrupt line comes with a set status flag, and that the flag never drops without a clear strobe. The bench scenarios are needed for the rest: the order in which match points fire, clamping a match value that lies at or above reload, the zero-count rule with overflow interrupts switched off, the restart on enable and on a reload write from zero, and counting on external tick strobes. The bench compares all three outputs on every clock against a cycle model of its own.

// File: rtl/dmt_pkg.sv
// Package dmt_pkg
// Shared types for the dual-match timer. It classifies what a tick produced.
// Assumes: nothing beyond IEEE 1800-2017.
package dmt_pkg;

    // Outcome of one tick, as decided by the match evaluator
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_MATCH = 2'd1,
        EV_ZERO  = 2'd2
    } dmt_event_e;

endpackage

// File: rtl/dmt_tick_gen.sv
// Module dmt_tick_gen
// Picks the count tick: every system clock, or the external strobe.
// Assumes: ext_tick is already synchronous to clk and lasts one clock.
module dmt_tick_gen (
    input  logic tick_sel,
    input  logic ext_tick,
    output logic tick
);

    // Select the tick source
    always_comb begin
        tick = tick_sel ? ext_tick : 1'b1;
    end

endmodule

// File: rtl/dmt_count_core.sv
// Module dmt_count_core
// Holds the running count and the registered enable. It applies the
// restart-on-enable rule, direct count writes, the start on a reload write
// from zero, and the decrement/wrap on a tick.
// Assumes: reload_q is the held reload and reload_d the value it takes next.
module dmt_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic         count_wr,
    input  logic [W-1:0] count_wdata,
    input  logic         reload_wr,
    input  logic [W-1:0] reload_wdata,
    input  logic [W-1:0] reload_q,
    input  logic [W-1:0] reload_d,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         step,
    output logic         run_q
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_d;
    logic         restart;
    logic         reload_start;

    // Value the count takes if a tick is accepted
    always_comb begin
        cnt_nxt = (cnt_q == ZERO) ? reload_q : (cnt_q - ONE);
    end

    // Decode the control cases in priority order
    always_comb begin
        restart      = run_en && !run_q;
        reload_start = reload_wr && (reload_q == ZERO) && (reload_wdata != ZERO);
        step         = 1'b0;
        cnt_d        = cnt_q;
        if (restart) begin
            cnt_d = reload_d;
        end else if (run_en) begin
            if (count_wr) begin
                cnt_d = count_wdata;
            end else if (reload_start) begin
                cnt_d = reload_wdata;
            end else if (tick && (reload_q != ZERO)) begin
                step  = 1'b1;
                cnt_d = cnt_nxt;
            end
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Registered enable, used to find the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_en;
        end
    end

endmodule

// File: rtl/dmt_match_eval.sv
// Module dmt_match_eval
// Clamps each match point against reload and classifies the tick outcome.
// Assumes: cnt_nxt is the count that the accepted tick produces.
module dmt_match_eval
    import dmt_pkg::*;
#(
    parameter int W  = 32,
    parameter int NM = 2
) (
    input  logic                 step,
    input  logic                 ovf_irq_en,
    input  logic [W-1:0]         reload_q,
    input  logic [NM-1:0][W-1:0] match_q,
    input  logic [W-1:0]         cnt_nxt,
    output dmt_event_e           ev_kind
);

    logic [NM-1:0][W-1:0] eff;
    logic [NM-1:0]        hit;
    logic [NM-1:0]        is_zero;

    for (genvar gi = 0; gi < NM; gi++) begin : g_point
        // Clamp one match point and compare it with the new count
        always_comb begin
            eff[gi]     = (match_q[gi] >= reload_q) ? '0 : match_q[gi];
            is_zero[gi] = (eff[gi] == '0);
            hit[gi]     = (cnt_nxt != '0) && (cnt_nxt == eff[gi]);
        end
    end

    // Merge the per-point results into one event
    always_comb begin
        ev_kind = EV_NONE;
        if (step) begin
            if (cnt_nxt == '0) begin
                if (ovf_irq_en || (|is_zero)) begin
                    ev_kind = EV_ZERO;
                end
            end else if (|hit) begin
                ev_kind = EV_MATCH;
            end
        end
    end

endmodule

// File: rtl/dmt_irq_out.sv
// Module dmt_irq_out
// Inverts the interrupt line on each event and keeps the sticky flag.
// Assumes: at most one event per clock.
module dmt_irq_out
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dmt_event_e ev_kind,
    input  logic       status_clr,
    output logic       irq_level,
    output logic       irq_status
);

    logic ev;

    // Any classified outcome is an event
    always_comb begin
        ev = (ev_kind != EV_NONE);
    end

    // Interrupt line inverts on each event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
        end else if (ev) begin
            irq_level <= ~irq_level;
        end
    end

    // Sticky flag: an event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_status <= 1'b0;
        end else if (ev) begin
            irq_status <= 1'b1;
        end else if (status_clr) begin
            irq_status <= 1'b0;
        end
    end

endmodule

// File: rtl/dmatch_timer.sv
// Module dmatch_timer
// One down-counting timer channel with two match points and a level-toggle
// interrupt. Holds the reload and match registers and wires the tick
// source, the count core, the match evaluator and the interrupt output.
// Assumes: write strobes last one clock; all inputs are synchronous to clk.
module dmatch_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sel,
    input  logic             ext_tick,
    input  logic             run_en,
    input  logic             ovf_irq_en,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_wdata,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             match_a_wr,
    input  logic [CNT_W-1:0] match_a_wdata,
    input  logic             match_b_wr,
    input  logic [CNT_W-1:0] match_b_wdata,
    input  logic             status_clr,
    output logic [CNT_W-1:0] count_out,
    output logic             irq_level,
    output logic             irq_status
);

    localparam int NM = 2;

    logic [CNT_W-1:0]         reload_q;
    logic [CNT_W-1:0]         reload_d;
    logic [NM-1:0][CNT_W-1:0] match_q;
    logic [NM-1:0][CNT_W-1:0] match_wdata_v;
    logic [NM-1:0]            match_wr_v;
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         cnt_nxt;
    logic                     step;
    logic                     run_q;
    logic                     tick;
    dmt_event_e               ev_kind;

    // Gather the match write ports into vectors
    always_comb begin
        match_wr_v       = {match_b_wr, match_a_wr};
        match_wdata_v[0] = match_a_wdata;
        match_wdata_v[1] = match_b_wdata;
    end

    // Next reload value
    always_comb begin
        reload_d = reload_wr ? reload_wdata : reload_q;
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            reload_q <= reload_d;
        end
    end

    for (genvar gm = 0; gm < NM; gm++) begin : g_match
        // Match register for one point
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[gm] <= '0;
            end else if (match_wr_v[gm]) begin
                match_q[gm] <= match_wdata_v[gm];
            end
        end
    end

    dmt_tick_gen u_tick (
        .tick_sel (tick_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    dmt_count_core #(.W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .tick         (tick),
        .count_wr     (count_wr),
        .count_wdata  (count_wdata),
        .reload_wr    (reload_wr),
        .reload_wdata (reload_wdata),
        .reload_q     (reload_q),
        .reload_d     (reload_d),
        .cnt_q        (cnt_q),
        .cnt_nxt      (cnt_nxt),
        .step         (step),
        .run_q        (run_q)
    );

    dmt_match_eval #(.W(CNT_W), .NM(NM)) u_match (
        .step       (step),
        .ovf_irq_en (ovf_irq_en),
        .reload_q   (reload_q),
        .match_q    (match_q),
        .cnt_nxt    (cnt_nxt),
        .ev_kind    (ev_kind)
    );

    dmt_irq_out u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_kind    (ev_kind),
        .status_clr (status_clr),
        .irq_level  (irq_level),
        .irq_status (irq_status)
    );

    // Visible count: live while enabled, reload while disabled
    always_comb begin
        count_out = run_q ? cnt_q : reload_q;
    end

endmodule

// File: rtl/dmatch_timer_chk.sv
// Module dmatch_timer_chk
// Assertion checker bound to dmatch_timer. It observes the ports and the
// reload register.
// Assumes: the clock and reset of the bound instance.
module dmatch_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             reload_wr,
    input logic             status_clr,
    input logic [CNT_W-1:0] count_out,
    input logic             irq_level,
    input logic             irq_status
);

    // R4: a disabled channel never moves its interrupt line
    a_r4_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(irq_level));

    // R4: a channel that stays disabled keeps its count output steady
    a_r4_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !$past(run_en) && !reload_wr) |=> $stable(count_out));

    // R11: every change of the line comes with the status flag set
    a_r11_toggle_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != $past(irq_level)) |-> irq_status);

    // R12: the flag drops only after a clear strobe
    a_r12_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !status_clr) |=> irq_status);

endmodule

bind dmatch_timer dmatch_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .reload_wr  (reload_wr),
    .status_clr (status_clr),
    .count_out  (count_out),
    .irq_level  (irq_level),
    .irq_status (irq_status)
);

// File: tb/dmatch_timer_test.sv
module dmatch_timer_test;

    localparam int PERIOD = 10;
    localparam int W      = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_sel = 1'b0;
    logic         ext_tick = 1'b0;
    logic         run_en = 1'b0;
    logic         ovf_irq_en = 1'b0;
    logic         count_wr = 1'b0;
    logic [W-1:0] count_wdata = '0;
    logic         reload_wr = 1'b0;
    logic [W-1:0] reload_wdata = '0;
    logic         match_a_wr = 1'b0;
    logic [W-1:0] match_a_wdata = '0;
    logic         match_b_wr = 1'b0;
    logic [W-1:0] match_b_wdata = '0;
    logic         status_clr = 1'b0;
    logic [W-1:0] count_out;
    logic         irq_level;
    logic         irq_status;

    int errors = 0;
    int checks = 0;
    string tag = "R1";
    int ext_period = 0;
    int ext_phase = 0;

    // Bench model state
    logic [W-1:0] m_cnt = '0, m_rel = '0, m_a = '0, m_b = '0;
    logic         m_run = 1'b0, m_lvl = 1'b0, m_st = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dmatch_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .ext_tick(ext_tick),
        .run_en(run_en), .ovf_irq_en(ovf_irq_en),
        .count_wr(count_wr), .count_wdata(count_wdata),
        .reload_wr(reload_wr), .reload_wdata(reload_wdata),
        .match_a_wr(match_a_wr), .match_a_wdata(match_a_wdata),
        .match_b_wr(match_b_wr), .match_b_wdata(match_b_wdata),
        .status_clr(status_clr), .count_out(count_out),
        .irq_level(irq_level), .irq_status(irq_status)
    );

    function automatic logic [W-1:0] clamp(logic [W-1:0] m, logic [W-1:0] r);
        return (m >= r) ? '0 : m;
    endfunction

    function automatic logic tick_event(logic [W-1:0] n, logic [W-1:0] ea,
                                        logic [W-1:0] eb, logic ovf);
        if (n == '0) return ovf || ea == '0 || eb == '0;
        return n == ea || n == eb;
    endfunction

    // Cycle model of the requirements, advanced at each clock
    always @(posedge clk) begin
        logic [W-1:0] old_rel, new_rel, nxt;
        logic ev, tk;
        ev = 1'b0;
        if (!rst_n) begin
            m_cnt = '0; m_rel = '0; m_a = '0; m_b = '0;
            m_run = 1'b0; m_lvl = 1'b0; m_st = 1'b0;
        end else begin
            old_rel = m_rel;
            new_rel = reload_wr ? reload_wdata : m_rel;
            tk = tick_sel ? ext_tick : 1'b1;
            if (run_en && !m_run) begin
                m_cnt = new_rel;
            end else if (run_en) begin
                if (count_wr) m_cnt = count_wdata;
                else if (reload_wr && old_rel == '0 && reload_wdata != '0) m_cnt = reload_wdata;
                else if (tk && old_rel != '0) begin
                    nxt = (m_cnt == '0) ? old_rel : m_cnt - 1;
                    ev = tick_event(nxt, clamp(m_a, old_rel), clamp(m_b, old_rel), ovf_irq_en);
                    m_cnt = nxt;
                end
            end
            if (ev) begin m_lvl = ~m_lvl; m_st = 1'b1; end
            else if (status_clr) m_st = 1'b0;
            m_rel = new_rel;
            if (match_a_wr) m_a = match_a_wdata;
            if (match_b_wr) m_b = match_b_wdata;
            m_run = run_en;
        end
    end

    task automatic compare();
        logic [W-1:0] exp_cnt;
        exp_cnt = m_run ? m_cnt : m_rel;
        checks += 3;
        if (count_out !== exp_cnt) begin
            errors++;
            $display("FAIL %s count_out actual=%0d expected=%0d at %0t", tag, count_out, exp_cnt, $time);
        end
        if (irq_level !== m_lvl) begin
            errors++;
            $display("FAIL %s irq_level actual=%0b expected=%0b at %0t", tag, irq_level, m_lvl, $time);
        end
        if (irq_status !== m_st) begin
            errors++;
            $display("FAIL %s irq_status actual=%0b expected=%0b at %0t", tag, irq_status, m_st, $time);
        end
    endtask

    // Advance n clocks, checking at each falling edge
    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            count_wr = 1'b0; reload_wr = 1'b0; match_a_wr = 1'b0;
            match_b_wr = 1'b0; status_clr = 1'b0;
            if (ext_period > 0) begin
                ext_phase++;
                ext_tick = (ext_phase % ext_period) == 0;
            end
        end
    endtask

    task automatic set_reload(logic [W-1:0] v);
        reload_wr = 1'b1; reload_wdata = v; run(1);
    endtask

    task automatic set_matches(logic [W-1:0] a, logic [W-1:0] b);
        match_a_wr = 1'b1; match_a_wdata = a;
        match_b_wr = 1'b1; match_b_wdata = b; run(1);
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; run(2);                          // reset state

        tag = "R7"; run_en = 1'b1; run(5);           // reload 0: idle
        set_reload(32'd10); run(6);                  // start from 10

        tag = "R2"; run(25);                         // decrement and wrap

        tag = "R9"; set_matches(32'd7, 32'd3); run(30);   // A then B fire
        set_matches(32'd3, 32'd7); run(24);               // order independent of slot

        tag = "R8"; set_matches(32'd15, 32'd10); run(24); // both clamp to zero
        tag = "R10"; set_matches(32'd6, 32'd4); ovf_irq_en = 1'b0; run(24);
        ovf_irq_en = 1'b1; run(24);
        tag = "R11"; set_matches(32'd5, 32'd5); ovf_irq_en = 1'b0; run(24);

        tag = "R3"; tick_sel = 1'b1; ext_period = 4; run(60);
        ext_period = 0; ext_tick = 1'b0; run(8);
        tick_sel = 1'b0;

        tag = "R6"; count_wr = 1'b1; count_wdata = 32'd8; run(12);
        tag = "R4"; run_en = 1'b0; run(10);
        count_wr = 1'b1; count_wdata = 32'd2; run(3);
        set_reload(32'd20); run(6);
        tag = "R5"; run_en = 1'b1; run(30);
        run_en = 1'b0; run(2); run_en = 1'b1; set_reload(32'd12); run(20);

        tag = "R12"; status_clr = 1'b1; run(1); run(3);
        set_matches(32'd1, 32'd1); run(10);
        status_clr = 1'b1; run(1); run(15);

        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 2) begin count_wr = 1'b1; count_wdata = $urandom_range(40); end
            if ($urandom_range(99) < 2) begin reload_wr = 1'b1; reload_wdata = $urandom_range(30); end
            if ($urandom_range(99) < 3) begin match_a_wr = 1'b1; match_a_wdata = $urandom_range(35); end
            if ($urandom_range(99) < 3) begin match_b_wr = 1'b1; match_b_wdata = $urandom_range(35); end
            if ($urandom_range(99) < 1) run_en = ~run_en;
            if ($urandom_range(99) < 2) ovf_irq_en = ~ovf_irq_en;
            if ($urandom_range(99) < 1) tick_sel = ~tick_sel;
            if ($urandom_range(99) < 5) status_clr = 1'b1;
            ext_tick = ($urandom_range(99) < 30);
            run(1);
        end
        finish_up();
    end

endmodule